// File: doc/BRIEF.md
# PCM Frame Serial Port

This block is a synchronous serial port that trades one 8-bit PCM word in each direction once per sampling frame. Its clock is the 2.048 MHz bit clock. A frame is 256 bit slots long, which is 125 µs at that rate. A frame sync input marks where each frame begins. Only the first eight slots of a frame carry data. The rest of the frame is idle, and during that time the serial output is released to high impedance so that other devices can share the line.

On the transmit side, a parallel load port writes a staging register. The staged word moves into a shift register at the start of slot 0. It then leaves on the serial output with the sign bit first. On the receive side, the block samples the serial input on the falling clock edge in each data slot. When slot 7 ends, the collected bits are moved into a parallel receive register and a one-cycle valid strobe is raised. The receive register then holds that word until the next frame replaces it. If frame sync pulses stop arriving, the slot counter keeps running with a 256-slot period, so the port keeps exchanging words at the frame rate.

Top module: `pcm_frame_port`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first clock edge, `tx_oe` is 0, `rx_valid` is 0 and `rx_data` is 0. The slot counter rests at slot 255, so the first edge after reset enters slot 0.
- R2: A clock edge at which `fsync` is sampled high, after being sampled low at the edge before, begins slot 0. Right after that edge `tx_oe` is 1. This is true whichever slot was current.
- R3: During slot k (k = 0 to 7), `ser_out` carries bit 7−k of the transmit word. Bit 7 (the sign) comes first. The value changes just after the rising edge that begins the slot.
- R4: `tx_oe` is 1 in slots 0 to 7 and 0 in slots 8 to 255. While `tx_oe` is 0, `ser_out` is high impedance.
- R5: A pulse on `tx_load` copies `tx_data` into a staging register at that edge. The staging register is moved into the transmit shifter only at the edge that begins slot 0. A load made later in a frame, or at that same edge, is therefore sent in the following frame.
- R6: `ser_in` is sampled on the falling clock edge in slots 0 to 7. The first bit received becomes bit 7 of `rx_data`.
- R7: `rx_valid` is high for exactly one cycle, namely slot 8, after the edge that ends slot 7. `rx_data` takes the new word at that same edge.
- R8: If no rising `fsync` arrives, the slot counter wraps from 255 to 0, and framing repeats every 256 cycles.
- R9: If `fsync` stays high for several cycles, only its rising edge restarts the frame. A steady high level acts like an absent sync.
- R10: `ser_in` values in slots 8 to 255 have no effect on `rx_data`. `rx_data` changes only at the edge that raises `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync; a rising edge starts slot 0 |
| tx_load | input | 1 | Strobe that writes `tx_data` into the staging register |
| tx_data | input | 8 | Parallel transmit word |
| ser_in | input | 1 | Serial receive data, sampled on the falling edge |
| ser_out | output | 1 | Serial transmit data, high impedance outside slots 0–7 |
| tx_oe | output | 1 | High while `ser_out` is driven |
| rx_data | output | 8 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe when `rx_data` is refreshed |

## Verification
The hardest situations to produce are frame restarts that do not match the steady 256-slot rhythm. Examples are a sync that rises in the middle of the data window, a sync level that stays high across a frame boundary, and a transmit load that lands on the very edge that begins slot 0. The stimulus runs a series of phases for these cases: regular sync pulses, no sync at all, a long high sync, a sync that arrives early at slot 100, and a sync that arrives at slot 3. Throughout all of them it drives random serial input and makes random parallel loads. An independent slot and shift model in the bench predicts every output on every cycle, so these restarts and races are checked in the same way as ordinary frames.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

  localparam int unsigned DEF_WORD_W = 8;
  localparam int unsigned DEF_FRAME_SLOTS = 256;

  // Slot that follows `cur`: a rising sync forces slot 0, else wrap at `slots`.
  function automatic int unsigned next_slot(int unsigned cur, logic rise,
                                            int unsigned slots);
    if (rise) return 0;
    if (cur + 1 >= slots) return 0;
    return cur + 1;
  endfunction

  // True while slot `s` carries one of the `w` data bits.
  function automatic logic in_window(int unsigned s, int unsigned w);
    return s < w;
  endfunction

endpackage

// File: rtl/pcm_slot_timer.sv
module pcm_slot_timer
  import pcm_port_pkg::*;
#(
  parameter int unsigned FRAME_SLOTS = DEF_FRAME_SLOTS,
  localparam int unsigned SLOT_W = $clog2(FRAME_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  output logic [SLOT_W-1:0] slot,
  output logic [SLOT_W-1:0] slot_nxt,
  output logic              fs_rise
);

  logic fs_q;

  assign fs_rise  = fsync & ~fs_q;
  assign slot_nxt = SLOT_W'(next_slot(int'(slot), fs_rise, FRAME_SLOTS));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q <= 1'b0;
      slot <= SLOT_W'(FRAME_SLOTS - 1);
    end else begin
      fs_q <= fsync;
      slot <= slot_nxt;
    end
  end

endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot_nxt,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_data,
  output logic [WORD_W-1:0] tx_sh,
  output logic              tx_msb
);

  logic [WORD_W-1:0] stage_q;
  logic              start_frame;
  logic              shift_step;

  assign start_frame = (slot_nxt == '0);
  assign shift_step  = !start_frame && in_window(int'(slot_nxt), WORD_W);
  assign tx_msb      = tx_sh[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      tx_sh   <= '0;
    end else begin
      if (tx_load) stage_q <= tx_data;
      if (start_frame)     tx_sh <= stage_q;
      else if (shift_step) tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic              ser_in,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_last
);

  logic [WORD_W-1:0] rx_sh;

  assign rx_last = (slot == SLOT_W'(WORD_W - 1));

  // Falling-edge sampling inside the data window.
  always_ff @(negedge clk) begin
    if (!rst_n)                                 rx_sh <= '0;
    else if (in_window(int'(slot), WORD_W))     rx_sh <= {rx_sh[WORD_W-2:0], ser_in};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= rx_last;
      if (rx_last) rx_data <= rx_sh;
    end
  end

endmodule

// File: rtl/pcm_frame_port.sv
module pcm_frame_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W = DEF_WORD_W,
  parameter int unsigned FRAME_SLOTS = DEF_FRAME_SLOTS,
  localparam int unsigned SLOT_W = $clog2(FRAME_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fsync,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              tx_oe,
  output logic [WORD_W-1:0] rx_data,
  output logic              rx_valid
);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] slot_nxt;
  logic              fs_rise;
  logic [WORD_W-1:0] tx_sh;
  logic              tx_msb;
  logic              rx_last;

  pcm_slot_timer #(.FRAME_SLOTS(FRAME_SLOTS)) u_timer (
    .clk(clk), .rst_n(rst_n), .fsync(fsync),
    .slot(slot), .slot_nxt(slot_nxt), .fs_rise(fs_rise)
  );

  pcm_tx_path #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .slot_nxt(slot_nxt),
    .tx_load(tx_load), .tx_data(tx_data), .tx_sh(tx_sh), .tx_msb(tx_msb)
  );

  pcm_rx_path #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .slot(slot), .ser_in(ser_in),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_last(rx_last)
  );

  assign tx_oe   = rst_n && in_window(int'(slot), WORD_W);
  assign ser_out = tx_oe ? tx_msb : 1'bz;

endmodule

// File: rtl/pcm_frame_port_chk.sv
module pcm_frame_port_chk #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned SLOT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] slot,
  input logic              fs_rise,
  input logic [WORD_W-1:0] tx_sh,
  input logic              tx_oe,
  input logic [WORD_W-1:0] rx_data,
  input logic              rx_valid
);

  assert_sync_starts_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fs_rise |=> tx_oe);

  assert_valid_outside_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !tx_oe);

  assert_shifter_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_oe |-> $stable(tx_sh));

  assert_valid_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_rx_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  assert_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == '1 && !fs_rise) |=> (slot == '0));

endmodule

bind pcm_frame_port pcm_frame_port_chk #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slot(slot), .fs_rise(fs_rise), .tx_sh(tx_sh),
  .tx_oe(tx_oe), .rx_data(rx_data), .rx_valid(rx_valid)
);

// File: tb/pcm_frame_port_tb.sv
module pcm_frame_port_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fsync = 1'b0;
  logic       tx_load = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic       ser_in = 1'b0;
  wire        ser_out;
  logic       tx_oe;
  logic [7:0] rx_data;
  logic       rx_valid;

  pcm_frame_port u_dut (
    .clk(clk), .rst_n(rst_n), .fsync(fsync), .tx_load(tx_load),
    .tx_data(tx_data), .ser_in(ser_in), .ser_out(ser_out), .tx_oe(tx_oe),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  always #5 clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // model state
  int unsigned m_slot = 255;
  bit          fs_prev = 1'b0;
  logic [7:0]  m_stage = 8'h00, m_word = 8'h00, m_rsh = 8'h00, m_rx = 8'h00;
  bit          m_valid = 1'b0;
  string       tx_tag = "R3";

  // drive requests for the next cycle
  bit d_fs = 0, d_load = 0, d_in = 0;
  logic [7:0] d_data = 8'h00;

  function automatic bit exp_oe(int unsigned s);
    return s <= 7;
  endfunction

  task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      if (miscompares < 20)
        $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic tick();
    bit rose;
    int unsigned old;
    @(posedge clk);
    rose = fsync && !fs_prev;
    fs_prev = fsync;
    old = m_slot;
    m_slot = rose ? 0 : ((m_slot + 1) % 256);
    m_valid = (old == 7);
    if (old == 7) m_rx = m_rsh;
    if (m_slot == 0) m_word = m_stage;
    if (tx_load) m_stage = tx_data;
    #2;
    fsync = d_fs; tx_load = d_load; tx_data = d_data; ser_in = d_in;
    if (m_slot <= 7) m_rsh = {m_rsh[6:0], d_in};
    #1;
    check(tx_oe == exp_oe(m_slot), (rose ? "R2" : "R4"), {7'd0, tx_oe}, {7'd0, exp_oe(m_slot)});
    if (m_slot <= 7)
      check(ser_out === m_word[7 - m_slot], tx_tag, {7'd0, ser_out}, {7'd0, m_word[7 - m_slot]});
    check(rx_valid == m_valid, "R7", {7'd0, rx_valid}, {7'd0, m_valid});
    check(rx_data == m_rx, (m_valid ? "R6" : "R10"), rx_data, m_rx);
  endtask

  // random serial input and occasional parallel loads
  task automatic rand_inputs();
    d_in = 1'($urandom);
    d_load = ($urandom % 40) == 0;
    d_data = 8'($urandom);
  endtask

  task automatic frames(int n, bit with_sync);
    for (int f = 0; f < n; f++)
      for (int c = 0; c < 256; c++) begin
        rand_inputs();
        d_fs = with_sync && (c < 2);
        tick();
      end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(posedge clk);
    #3;
    check(tx_oe == 1'b0, "R1", {7'd0, tx_oe}, 8'd0);
    check(rx_valid == 1'b0, "R1", {7'd0, rx_valid}, 8'd0);
    check(rx_data == 8'h00, "R1", rx_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(tx_oe == 1'b0, "R1", {7'd0, tx_oe}, 8'd0);

    // directed: known word with load before frame start
    d_data = 8'hA5; d_load = 1; tick();
    d_load = 0;
    tx_tag = "R3";
    frames(3, 1'b1);

    // load on the same edge that begins slot 0 (sent one frame later)
    tx_tag = "R5";
    for (int c = 0; c < 255; c++) begin rand_inputs(); d_load = 0; d_fs = 0; tick(); end
    d_data = 8'h3C; d_load = 1; d_fs = 1; tick();
    d_load = 0; d_fs = 0;
    frames(2, 1'b1);

    // free running, no sync
    tx_tag = "R8";
    frames(3, 1'b0);

    // sync held high across several frames
    tx_tag = "R9";
    for (int c = 0; c < 600; c++) begin rand_inputs(); d_fs = 1; tick(); end
    d_fs = 0;

    // early sync at slot 100 and in the data window
    tx_tag = "R2";
    for (int c = 0; c < 100; c++) begin rand_inputs(); d_fs = (c == 0); tick(); end
    for (int c = 0; c < 260; c++) begin rand_inputs(); d_fs = (c == 0) || (c == 4); tick(); end

    tx_tag = "R3";
    frames(3, 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!finished) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog at %0t: actual hung expected done", $time);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule